// File: doc/BRIEF.md
# Flash Busy-Status Read Path

This block forms the byte a parallel flash returns on each host read. While the memory is idle, the array byte goes to the read bus unchanged. While an embedded program or erase runs, two bits of that byte are replaced by completion indicators. The host can poll either one to learn when the operation has finished.

The top bit is the data-poll bit. During a program it carries the inverse of the top bit of the byte being written. During an erase it reads 0, because an erased cell reads 1. The bit below it is a toggle bit. It changes value each time a read access completes, so two back-to-back reads differ for as long as the operation runs. When the busy flag drops, both bits show array data again. The busy flag, the operation type and the pending byte come from the embedded-algorithm controller, which lies outside this block.

Top module: `flash_status_read`

## Requirements
- R1: While `busy` is 1 and `op_erase` is 0, `rd_data[7]` equals the inverse of `load_data[7]`.
- R2: While `busy` is 1 and `op_erase` is 1, `rd_data[7]` is 0.
- R3: While `busy` is 0, `rd_data` equals `array_data` on all eight bits.
- R4: While `busy` is 1, `rd_data[6]` shows the toggle state. A read completes on the first clock edge at which `rd_strobe` is sampled 0 after having been sampled 1. Each completed read inverts the toggle state, so the first read of an operation returns 0, the next returns 1, and so on.
- R5: The toggle state changes only when a read completes. Idle clocks during an operation leave it unchanged, so polling that starts late in an operation still sees the sequence 0, 1, 0, ...
- R6: On the clock edge at which `busy` is first sampled 1 after being 0, the toggle state is cleared to 0. This applies even if an earlier operation left it at 1, and it takes priority over a read completing on that edge.
- R7: While `busy` is 1, `rd_data[5:0]` equals `array_data[5:0]`.
- R8: After reset the toggle state is 0, and the state from before reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Embedded program or erase in progress |
| op_erase | input | 1 | 1 when the running operation is an erase |
| load_data | input | 8 | Byte being programmed |
| array_data | input | 8 | Byte read from the memory array |
| rd_strobe | input | 1 | Host read access active (high) |
| rd_data | output | 8 | Byte presented to the host read bus |

## Verification
The hardest case to reach is a stale toggle state carried into a new operation. It arises only when an operation ends after an odd number of completed reads and the next one starts. The bench performs one read in a first operation, drops `busy`, raises it again and checks that the next read returns 0. A separate scenario runs many clocks with `busy` high and no reads before polling begins. This shows the toggle sequence is tied to read completions rather than to elapsed time.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  // Bit that carries the data-poll indicator for a bus width
  function automatic int poll_pos(input int w);
    return w - 1;
  endfunction

  // Bit that carries the toggle indicator for a bus width
  function automatic int tog_pos(input int w);
    return w - 2;
  endfunction

  // Value returned on the data-poll bit while busy
  function automatic logic poll_value(input logic erase, input logic pend_msb);
    logic ref_bit;
    ref_bit = erase ? 1'b1 : pend_msb;
    return ~ref_bit;
  endfunction

  // Next toggle state: start of operation clears, completed read inverts
  function automatic logic toggle_next(input logic cur, input logic start,
                                       input logic done);
    logic nxt;
    nxt = cur;
    if (start)     nxt = 1'b0;
    else if (done) nxt = ~cur;
    return nxt;
  endfunction

endpackage

// File: rtl/fsr_strobe_edge.sv
module fsr_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic fall_evt,
  output logic rise_evt
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end

  assign fall_evt = level_q & ~level_in;
  assign rise_evt = ~level_q & level_in;
endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic op_start,
  input  logic op_active,
  input  logic read_done,
  output logic tog_q
);
  import fsr_pkg::*;

  logic advance;
  assign advance = op_active & read_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= toggle_next(tog_q, op_start, advance);
  end
endmodule

// File: rtl/fsr_out_mux.sv
module fsr_out_mux #(
  parameter int DATA_W = 8
) (
  input  logic              busy,
  input  logic              op_erase,
  input  logic [DATA_W-1:0] load_data,
  input  logic [DATA_W-1:0] array_data,
  input  logic              tog_q,
  output logic [DATA_W-1:0] rd_data
);
  import fsr_pkg::*;

  localparam int PB = poll_pos(DATA_W);
  localparam int TB = tog_pos(DATA_W);

  logic poll_bit;
  assign poll_bit = poll_value(op_erase, load_data[PB]);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == PB) begin : g_poll
      assign rd_data[i] = busy ? poll_bit : array_data[i];
    end else if (i == TB) begin : g_tog
      assign rd_data[i] = busy ? tog_q : array_data[i];
    end else begin : g_pass
      assign rd_data[i] = array_data[i];
    end
  end
endmodule

// File: rtl/flash_status_read.sv
module flash_status_read #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              op_erase,
  input  logic [DATA_W-1:0] load_data,
  input  logic [DATA_W-1:0] array_data,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data
);
  logic read_done;
  logic read_begin;
  logic op_start;
  logic op_end;
  logic tog_q;

  fsr_strobe_edge u_rd_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (rd_strobe),
    .fall_evt (read_done),
    .rise_evt (read_begin)
  );

  fsr_strobe_edge u_busy_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (busy),
    .fall_evt (op_end),
    .rise_evt (op_start)
  );

  fsr_toggle u_tog (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_start  (op_start),
    .op_active (busy),
    .read_done (read_done),
    .tog_q     (tog_q)
  );

  fsr_out_mux #(.DATA_W(DATA_W)) u_mux (
    .busy       (busy),
    .op_erase   (op_erase),
    .load_data  (load_data),
    .array_data (array_data),
    .tog_q      (tog_q),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/flash_status_read_chk.sv
module flash_status_read_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              op_erase,
  input logic [DATA_W-1:0] load_data,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              read_done,
  input logic              op_start,
  input logic              tog_q
);
  a_r1_poll_program: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_erase) |-> (rd_data[DATA_W-1] != load_data[DATA_W-1]));

  a_r2_poll_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_erase) |-> (rd_data[DATA_W-1] == 1'b0));

  a_r3_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_data == array_data));

  a_r4_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && read_done && !op_start) |=> (tog_q != $past(tog_q)));

  a_r5_toggle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_done && !op_start) |=> $stable(tog_q));

  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> (tog_q == 1'b0));

  a_r7_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_data[DATA_W-3:0] == array_data[DATA_W-3:0]));
endmodule

bind flash_status_read flash_status_read_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .op_erase   (op_erase),
  .load_data  (load_data),
  .array_data (array_data),
  .rd_data    (rd_data),
  .read_done  (read_done),
  .op_start   (op_start),
  .tog_q      (tog_q)
);

// File: tb/flash_status_read_tb.sv
module flash_status_read_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0;
  logic       op_erase = 1'b0;
  logic [7:0] load_data = 8'h00;
  logic [7:0] array_data = 8'h00;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_data;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_status_read u_dut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
    .load_data(load_data), .array_data(array_data),
    .rd_strobe(rd_strobe), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] got,
                       input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // One read access: strobe high for one clock, sample, then release
  task automatic host_read(output logic [7:0] val);
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) val = rd_data;
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_op(input logic erase, input logic [7:0] pend);
    @(negedge clk);
    op_erase = erase; load_data = pend; busy = 1'b1;
    @(negedge clk);
  endtask

  task automatic end_op();
    @(negedge clk) busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    array_data = 8'h5A;
    #1; check("R8 idle after reset", rd_data, 8'h5A);
    start_op(1'b0, 8'h00);
    host_read(v);
    check("R8 toggle zero after reset", {7'd0, v[6]}, 8'h00);
    end_op();
  endtask

  task automatic t_idle();
    logic [7:0] v;
    for (int i = 0; i < 4; i++) begin
      array_data = 8'h3C ^ (8'h41 * i[7:0]);
      host_read(v);
      check("R3 idle passthrough", v, 8'h3C ^ (8'h41 * i[7:0]));
    end
  endtask

  task automatic t_program();
    logic [7:0] v;
    start_op(1'b0, 8'h80);
    array_data = 8'hFF;
    for (int i = 0; i < 4; i++) begin
      host_read(v);
      check("R1 poll bit program msb=1", {7'd0, v[7]}, 8'h00);
      check("R4 toggle sequence", {7'd0, v[6]}, {7'd0, i[0]});
      check("R7 low bits follow array", {2'b00, v[5:0]}, 8'h3F);
    end
    load_data = 8'h12; array_data = 8'h15;
    host_read(v);
    check("R1 poll bit program msb=0", {7'd0, v[7]}, 8'h01);
    check("R7 low bits follow array", {2'b00, v[5:0]}, 8'h15);
    end_op();
    array_data = 8'hC3; #1;
    check("R3 true data after completion", rd_data, 8'hC3);
  endtask

  task automatic t_erase();
    logic [7:0] v;
    start_op(1'b1, 8'h00);
    array_data = 8'h80;
    for (int i = 0; i < 3; i++) begin
      host_read(v);
      check("R2 erase poll bit zero", {7'd0, v[7]}, 8'h00);
      check("R4 toggle during erase", {7'd0, v[6]}, {7'd0, i[0]});
    end
    end_op();
  endtask

  task automatic t_late_poll();
    logic [7:0] v;
    start_op(1'b0, 8'h00);
    repeat (50) @(negedge clk);
    check("R5 no change without reads", {7'd0, rd_data[6]}, 8'h00);
    for (int i = 0; i < 3; i++) begin
      host_read(v);
      check("R5 late polling sequence", {7'd0, v[6]}, {7'd0, i[0]});
      repeat (7) @(negedge clk);
    end
    check("R5 holds between reads", {7'd0, rd_data[6]}, 8'h01);
    end_op();
  endtask

  task automatic t_restart();
    logic [7:0] v;
    start_op(1'b0, 8'h00);
    host_read(v);
    check("R4 first read zero", {7'd0, v[6]}, 8'h00);
    #1; check("R4 toggle advanced", {7'd0, rd_data[6]}, 8'h01);
    end_op();
    start_op(1'b1, 8'h00);
    host_read(v);
    check("R6 new operation clears toggle", {7'd0, v[6]}, 8'h00);
    end_op();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_program();
    t_erase();
    t_late_poll();
    t_restart();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule